// File: doc/BRIEF.md
# Serial Configuration PROM Loader

After reset, this block reads a board configuration image from a three-wire serial PROM (the read-only, word-organised kind). It needs no help from anything else. It drives the select, clock and serial data lines itself, with a pin timing that is slow enough for any such part at any system clock. First it issues one probe read to learn whether the attached part takes 6-bit or 8-bit word addresses. It then reads every word of the image in ascending order.

While the words stream past, the block keeps a 16-bit running sum and picks out three things: the 48-bit station address, the PHY management address and a receive-lockup workaround flag. When the last word has been read, it reports whether the image sum matches the fixed target and pulses a done strobe. From then on it keeps its results steady and leaves the PROM alone until the next reset. A network controller would use these outputs to configure itself before its host ever touches it.

Top module: `cfg_prom_loader`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, prom_sel, prom_clk, prom_mosi, load_done and image_ok are all low. No select rise comes earlier than one full phase after reset is released.
- R2: Every read transaction follows this pin sequence:
  - prom_sel rises with prom_clk low, then prom_clk gives one pulse while prom_mosi is low.
  - The 28 frame bits follow, most significant first. Each bit is placed on prom_mosi while prom_clk is low and is held through the high phase.
  - prom_clk then returns low for one phase, and only after that does prom_sel fall.
  - prom_clk is never high while prom_sel is low.
- R3: Every level on the three driven pins lasts at least PHASE_CYC clocks. PHASE_CYC = ceil(CLK_FREQ_KHZ*PHASE_NS/1e6), and it is never below 1.
- R4: One prom_miso bit is captured at the end of each clock-high phase. The last 16 captured bits of a frame form the data word.
  - The first transaction is a probe in the long form: bit 27 is 0, bits 26:24 carry the read code 110, bits 23:16 carry the address 0, and bits 15:0 are 0.
  - If captured bits 27:17 of the probe are all one, the part holds 256 words and every read uses the long form.
  - Otherwise the part holds 64 words and every read uses the short form: bits 27:25 are 0, bits 24:22 are 110, bits 21:16 carry the address, and bits 15:0 are 0.
- R5: After the probe, each word from 0 up to the last one (63 or 255) is read exactly once, in ascending order, one transaction per word.
- R6: image_ok goes high together with load_done exactly when the 16-bit wrapping sum of all words read equals CSUM_TARGET (default 16'hBABA). Otherwise it stays low.
- R7: mac_addr = {word2, word1, word0}. Its bits 7:0 hold the low byte of word 0, which is the first address byte; each word contributes its low byte before its high byte.
- R8: lockup_fix is high when bits 1:0 of word 3 are anything other than 2'b11. phy_addr equals bits 4:0 of word 6.
- R9: load_done is high for exactly one clock, once the select has dropped after the last word. image_ok is low before that clock.
- R10: After load_done, prom_sel stays low and mac_addr, phy_addr, lockup_fix and image_ok hold their values until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a new load when released |
| prom_miso | input | 1 | Serial data from the PROM (idles high when not driven) |
| prom_sel | output | 1 | PROM chip select, active high |
| prom_clk | output | 1 | PROM serial clock |
| prom_mosi | output | 1 | Serial data to the PROM |
| mac_addr | output | 48 | Station address, first byte in bits 7:0 |
| phy_addr | output | 5 | PHY management address from word 6 |
| lockup_fix | output | 1 | Receive-lockup workaround required |
| image_ok | output | 1 | Image sum matched the target |
| load_done | output | 1 | One-clock strobe at the end of the load |

## Verification
load_done and image_ok are registered on the same edge, which comes one phase after the select drops on the last word. The bench therefore samples both on the falling clock edge where load_done is first seen high, and samples load_done again one cycle later to confirm it has fallen. mac_addr, lockup_fix and phy_addr are written as words 0–2, 3 and 6 arrive, well before the strobe, so they are compared in the done cycle. They are then compared once more against that snapshot for 40 cycles afterwards, which covers the hold requirement. Pin timing has no fixed deadline, so a falling-edge monitor tracks the length of every pin level and every select and clock transition continuously across each load, and the bench checks its violation count once the load ends.

// File: rtl/cfg_prom_loader.sv
module cfg_prom_loader #(
  parameter int          CLK_FREQ_KHZ = 250_000,
  parameter int          PHASE_NS     = 2000,
  parameter logic [15:0] CSUM_TARGET  = 16'hBABA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prom_miso,
  output logic        prom_sel,
  output logic        prom_clk,
  output logic        prom_mosi,
  output logic [47:0] mac_addr,
  output logic [4:0]  phy_addr,
  output logic        lockup_fix,
  output logic        image_ok,
  output logic        load_done
);

  localparam int PHASE_RAW = (CLK_FREQ_KHZ * PHASE_NS + 999_999) / 1_000_000;
  localparam int PHASE_CYC = (PHASE_RAW < 1) ? 1 : PHASE_RAW;
  localparam int PW        = $clog2(PHASE_CYC + 1);
  localparam logic [PW-1:0] RELOAD = PW'(PHASE_CYC - 1);
  localparam int FRAME_W   = 28;
  localparam logic [2:0] RD_CODE = 3'b110;

  typedef enum logic [2:0] {ST_GAP, ST_SEL, ST_PULSE, ST_LO, ST_HI, ST_TAIL, ST_DONE} st_t;

  st_t               st;
  logic [PW-1:0]     ph_cnt;
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-2:0] rx;
  logic [4:0]        bit_idx;
  logic [7:0]        word_idx;
  logic              probing, wide, last_word;
  logic [15:0]       sum;

  wire phase_end = (ph_cnt == '0);
  wire [FRAME_W-1:0] captured = {rx, prom_miso};
  wire [7:0] top_word = wide ? 8'hFF : 8'h3F;
  wire [FRAME_W-1:0] rd_frame = (probing || wide) ? {1'b0, RD_CODE, word_idx, 16'h0000}
                                                  : {3'b000, RD_CODE, word_idx[5:0], 16'h0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ph_cnt <= RELOAD;
    else if (st == ST_DONE)        ph_cnt <= '0;
    else if (phase_end)            ph_cnt <= RELOAD;
    else                           ph_cnt <= ph_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_GAP;
      prom_sel   <= 1'b0;
      prom_clk   <= 1'b0;
      prom_mosi  <= 1'b0;
      frame      <= '0;
      rx         <= '0;
      bit_idx    <= '0;
      word_idx   <= '0;
      probing    <= 1'b1;
      wide       <= 1'b0;
      last_word  <= 1'b0;
      sum        <= '0;
      mac_addr   <= '0;
      phy_addr   <= '0;
      lockup_fix <= 1'b0;
      image_ok   <= 1'b0;
      load_done  <= 1'b0;
    end else begin
      load_done <= 1'b0;
      if (st != ST_DONE && phase_end) begin
        case (st)
          ST_GAP: begin
            if (last_word) begin
              st        <= ST_DONE;
              load_done <= 1'b1;
              image_ok  <= (sum == CSUM_TARGET);
            end else begin
              frame    <= rd_frame;
              prom_sel <= 1'b1;
              st       <= ST_SEL;
            end
          end
          ST_SEL: begin
            prom_clk <= 1'b1;
            st       <= ST_PULSE;
          end
          ST_PULSE: begin
            prom_clk  <= 1'b0;
            prom_mosi <= frame[FRAME_W-1];
            bit_idx   <= 5'(FRAME_W - 1);
            st        <= ST_LO;
          end
          ST_LO: begin
            prom_clk <= 1'b1;
            st       <= ST_HI;
          end
          ST_HI: begin
            prom_clk <= 1'b0;
            rx       <= captured[FRAME_W-2:0];
            if (bit_idx == 5'd0) begin
              prom_mosi <= 1'b0;
              st        <= ST_TAIL;
              if (probing) begin
                probing  <= 1'b0;
                wide     <= &captured[27:17];
                word_idx <= '0;
              end else begin
                sum <= sum + captured[15:0];
                case (word_idx)
                  8'd0: mac_addr[15:0]  <= captured[15:0];
                  8'd1: mac_addr[31:16] <= captured[15:0];
                  8'd2: mac_addr[47:32] <= captured[15:0];
                  8'd3: lockup_fix      <= (captured[1:0] != 2'b11);
                  8'd6: phy_addr        <= captured[4:0];
                  default: ;
                endcase
                if (word_idx == top_word) last_word <= 1'b1;
                else                      word_idx  <= word_idx + 8'd1;
              end
            end else begin
              prom_mosi <= frame[FRAME_W-2];
              frame     <= {frame[FRAME_W-2:0], 1'b0};
              bit_idx   <= bit_idx - 5'd1;
              st        <= ST_LO;
            end
          end
          ST_TAIL: begin
            prom_sel <= 1'b0;
            st       <= ST_GAP;
          end
          default: st <= ST_DONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_prom_loader_chk.sv
module cfg_prom_loader_chk #(
  parameter int PHASE_CYC = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        prom_sel,
  input logic        prom_clk,
  input logic        prom_mosi,
  input logic [47:0] mac_addr,
  input logic [4:0]  phy_addr,
  input logic        lockup_fix,
  input logic        image_ok,
  input logic        load_done
);

  logic        done_seen;
  logic [2:0]  pins_q;
  logic [31:0] run;
  wire  [2:0]  pins    = {prom_sel, prom_clk, prom_mosi};
  wire         pin_chg = (pins != pins_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_seen <= 1'b0;
      pins_q    <= '0;
      run       <= '0;
    end else begin
      if (load_done) done_seen <= 1'b1;
      pins_q <= pins;
      if (pin_chg)                 run <= 32'd1;
      else if (run != 32'hFFFF_FFFF) run <= run + 32'd1;
    end
  end

  AST_SK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    prom_clk |-> prom_sel); // R2
  AST_MOSI_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prom_clk) |-> $stable(prom_mosi)); // R2
  AST_CLK_LOW_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prom_sel) |-> (!prom_clk && !$past(prom_clk))); // R2
  AST_MIN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_chg |-> (run >= 32'(PHASE_CYC))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done); // R9
  AST_NO_EARLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_seen && !load_done) |-> !image_ok); // R9
  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    done_seen |=> ($stable(mac_addr) && $stable(phy_addr) && $stable(lockup_fix) && $stable(image_ok))); // R10
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_seen |-> !prom_sel); // R10

endmodule

bind cfg_prom_loader cfg_prom_loader_chk #(.PHASE_CYC(PHASE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .prom_sel(prom_sel), .prom_clk(prom_clk),
  .prom_mosi(prom_mosi), .mac_addr(mac_addr), .phy_addr(phy_addr),
  .lockup_fix(lockup_fix), .image_ok(image_ok), .load_done(load_done)
);

// File: tb/cfg_prom_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_prom_loader_tb_top;

  localparam int PHASE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prom_miso = 1'b1;
  logic prom_sel, prom_clk, prom_mosi;
  logic [47:0] mac_addr;
  logic [4:0]  phy_addr;
  logic lockup_fix, image_ok, load_done;

  always #2 clk = ~clk;

  cfg_prom_loader #(.CLK_FREQ_KHZ(250_000), .PHASE_NS(8), .CSUM_TARGET(16'hBABA)) dut_i (
    .clk(clk), .rst_n(rst_n), .prom_miso(prom_miso), .prom_sel(prom_sel),
    .prom_clk(prom_clk), .prom_mosi(prom_mosi), .mac_addr(mac_addr),
    .phy_addr(phy_addr), .lockup_fix(lockup_fix), .image_ok(image_ok),
    .load_done(load_done)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // PROM model
  logic [15:0] mem [256];
  int abits = 6;
  int m_state = 0, m_cnt = 0, m_cmd = 0, m_bitn = 0, m_addr = 0;
  int bad_op = 0;
  int log_n = 0;
  int log_a [300];

  always @(posedge prom_clk or negedge prom_sel) begin
    if (!prom_sel) begin
      m_state = 0;
      prom_miso <= 1'b1;
    end else begin
      case (m_state)
        0: if (prom_mosi) begin m_state = 1; m_cnt = 0; m_cmd = 0; end
        1: begin
          m_cmd = (m_cmd << 1) | int'(prom_mosi);
          m_cnt++;
          if (m_cnt == 2 + abits) begin
            if (((m_cmd >> abits) & 3) != 2) bad_op++;
            m_addr = m_cmd & ((1 << abits) - 1);
            if (log_n < 300) log_a[log_n] = m_addr;
            log_n++;
            m_state = 2;
            m_bitn = 16;
            prom_miso <= 1'b0;
          end
        end
        default: begin
          if (m_bitn > 0) begin
            prom_miso <= mem[m_addr][m_bitn-1];
            m_bitn--;
          end else prom_miso <= 1'b1;
        end
      endcase
    end
  end

  // pin timing monitor (R2, R3)
  logic [2:0] pins_q = '0;
  int run = 0, viol = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      run = 0;
      pins_q = '0;
    end else begin
      if ({prom_sel, prom_clk, prom_mosi} != pins_q) begin
        if (run < PHASE) viol++;
        if (prom_clk && !pins_q[1] && (prom_mosi != pins_q[0])) viol++;
        if (!prom_sel && pins_q[2] && (prom_clk || pins_q[1])) viol++;
        run = 1;
      end else run++;
      if (prom_clk && !prom_sel) viol++;
      pins_q = {prom_sel, prom_clk, prom_mosi};
    end
  end

  function automatic logic [15:0] sum_words(input int n);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s = s + mem[i];
    return s;
  endfunction

  task automatic run_load(input int ab, input int w3lo, input bit bad_sum);
    int nw;
    bit got;
    bit early_ok;
    logic [47:0] snap_mac;
    logic [4:0]  snap_phy;
    logic snap_fix, snap_ok;
    logic [47:0] exp_mac;
    bit order_ok;
    bit stay_ok;
    nw = 1 << ab;
    abits = ab;
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    if (w3lo >= 0) mem[3][1:0] = 2'(w3lo);
    mem[nw-1] = 16'h0000;
    mem[nw-1] = 16'hBABA - sum_words(nw) + (bad_sum ? 16'h0001 : 16'h0000);
    exp_mac = {mem[2], mem[1], mem[0]};

    rst_n = 1'b0;
    log_n = 0;
    bad_op = 0;
    repeat (3) @(negedge clk);
    check(!prom_sel && !prom_clk && !prom_mosi && !load_done && !image_ok, "R1",
          "pins/flags in reset", {prom_sel, prom_clk, prom_mosi, load_done, image_ok}, 0);
    viol = 0;
    rst_n = 1'b1;
    @(negedge clk);
    check(!prom_sel && !load_done && !image_ok, "R1", "state after release",
          {prom_sel, load_done, image_ok}, 0);

    got = 0;
    early_ok = 0;
    for (int c = 0; c < 40000 && !got; c++) begin
      @(negedge clk);
      if (load_done) got = 1;
      else if (image_ok) early_ok = 1;
    end
    check(got, "R9", "load_done seen", 64'(got), 1);
    if (!got) return;
    check(!early_ok, "R9", "image_ok low before done", 64'(early_ok), 0);
    check(image_ok == !bad_sum, "R6", "image_ok", 64'(image_ok), 64'(!bad_sum));
    check(mac_addr == exp_mac, "R7", "mac_addr", 64'(mac_addr), 64'(exp_mac));
    check(phy_addr == mem[6][4:0], "R8", "phy_addr", 64'(phy_addr), 64'(mem[6][4:0]));
    check(lockup_fix == (mem[3][1:0] != 2'b11), "R8", "lockup_fix", 64'(lockup_fix),
          64'(mem[3][1:0] != 2'b11));
    check(bad_op == 0, "R4", "read code errors", 64'(bad_op), 0);
    check(log_n == nw + 1, "R5", "transaction count", 64'(log_n), 64'(nw + 1));
    order_ok = (log_a[0] == 0);
    for (int i = 0; i < nw && i + 1 < 300; i++) if (log_a[i+1] != i) order_ok = 0;
    check(order_ok, "R5", "ascending word order", 64'(order_ok), 1);
    check(viol == 0, "R2", "pin sequence/phase violations (R3)", 64'(viol), 0);
    snap_mac = mac_addr; snap_phy = phy_addr; snap_fix = lockup_fix; snap_ok = image_ok;
    @(negedge clk);
    check(!load_done, "R9", "done width one cycle", 64'(load_done), 0);
    stay_ok = 1;
    for (int c = 0; c < 40; c++) begin
      if (prom_sel || load_done || mac_addr != snap_mac || phy_addr != snap_phy ||
          lockup_fix != snap_fix || image_ok != snap_ok) stay_ok = 0;
      @(negedge clk);
    end
    check(stay_ok, "R10", "quiet and held after done", 64'(stay_ok), 1);
  endtask

  initial begin
    void'($urandom(32'h0C0FFEE1));
    run_load(6, -1, 1'b0);
    run_load(8, -1, 1'b0);
    run_load(6, 3, 1'b1);
    run_load(8, 3, 1'b0);
    run_load(6, 1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule